// File: doc/BRIEF.md
# Clock-Domain Control Write Synchronizer

This block moves writes to a small control register from a bus clock domain into an unrelated core clock domain. The register has two control bits: a software reset and an enable. When the bus writes that register, the data is latched in the bus domain. A request toggle then travels to the core domain through a two-flop synchronizer. The core domain applies the new value and returns an acknowledge toggle through a second synchronizer. The bus side then ends the transaction.

While a transfer is in flight, a busy status is raised. When the acknowledge returns, busy drops and a one-cycle ready flag pulses. If another write to the control register arrives while busy is set, the bus is stalled (ready held low) until the earlier transfer finishes. The stalled write is then accepted and nothing is lost. Writes to any other address need no synchronization. They are accepted at once and have no effect here.

A software reset applied in the core domain clears the enable output and produces a core-clock pulse that clears itself after one cycle.

Top module: `regsync_xdom`

## Requirements
- R1: After both resets are released, sync_busy is 0, bus_ready is 1 while no write is presented, core_enable is 0, core_swrst is 0 and sync_ready_pulse is 0.
- R2: A write to the control address (CTRL_ADDR, default 0) is accepted at a bus clock edge where bus_wr and bus_ready are both 1. From the bus cycle after that edge, sync_busy reads 1.
- R3: When a transfer completes, sync_busy returns to 0 and sync_ready_pulse is high for exactly one bus cycle. Each accepted control write produces exactly one pulse, within 40 bus cycles of acceptance.
- R4: A control-address write presented while sync_busy is 1 sees bus_ready at 0 until sync_busy falls. It is then accepted and applied normally.
- R5: If a control write has bit 0 (software reset) at 0, then core_enable takes the value of bit 1 (enable) before the completion pulse of that write.
- R6: If a control write has bit 0 at 1, then core_swrst is high for exactly one core cycle, and core_enable is 0 from then on, whatever the value of bit 1.
- R7: A write to any other address is accepted with bus_ready at 1, even while busy. It raises no busy, no ready pulse and no core-side change.
- R8: The value applied in the core domain is the bus_wdata sampled at acceptance. Later changes of bus_wdata during the transfer have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus domain clock |
| bus_rst_n | input | 1 | Bus domain asynchronous active-low reset |
| bus_wr | input | 1 | Write request |
| bus_addr | input | AW | Write address |
| bus_wdata | input | DW | Write data (bit 0 software reset, bit 1 enable) |
| bus_ready | output | 1 | Low while a control write is stalled |
| sync_busy | output | 1 | A control transfer is in flight |
| sync_ready_pulse | output | 1 | One-cycle completion flag, bus domain |
| core_clk | input | 1 | Core domain clock |
| core_rst_n | input | 1 | Core domain asynchronous active-low reset |
| core_enable | output | 1 | Enable control, core domain |
| core_swrst | output | 1 | One-cycle software reset pulse, core domain |

## Verification
A request toggle that is lost or duplicated shows at the ports as a busy flag that never falls, or as a missing or extra ready pulse. Either appears within the 40-cycle completion window of the write that caused it. A holding register that is corrupted during a transfer shows as a wrong core_enable or an unexpected software-reset pulse once the transfer completes. A faulty stall decision shows in the very cycle the second write is presented: either bus_ready is high while busy, or a write is dropped and the ready-pulse count falls behind the accepted-write count.

// File: rtl/regsync_pkg.sv
package regsync_pkg;
  typedef struct packed {
    logic enable;
    logic swrst;
  } ctrl_bits_t;
endpackage

// File: rtl/regsync_rst_sync.sv
module regsync_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/regsync_sync_bits.sv
module regsync_sync_bits #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/regsync_bus_side.sv
module regsync_bus_side
  import regsync_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int CTRL_ADDR  = 0,
  parameter int SWRST_BIT  = 0,
  parameter int ENABLE_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ack_sync,
  output logic          ready,
  output logic          busy,
  output logic          rdy_pulse,
  output logic          req_tog,
  output ctrl_bits_t    held
);
  localparam logic [AW-1:0] CtrlAddr = AW'(CTRL_ADDR);

  logic          busy_q, busy_d;
  logic          req_q, req_d;
  logic          rdy_q, rdy_d;
  logic [DW-1:0] hold_q;
  logic          is_ctrl, hit, accept, done;

  always_comb begin
    is_ctrl = (addr == CtrlAddr);
    hit     = wr & is_ctrl;
    accept  = hit & ~busy_q;
    done    = busy_q & (ack_sync == req_q);
    busy_d  = busy_q;
    req_d   = req_q;
    rdy_d   = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      req_d  = ~req_q;
    end else if (done) begin
      busy_d = 1'b0;
      rdy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      rdy_q  <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (accept) hold_q <= wdata;
  end

  assign ready        = ~(hit & busy_q);
  assign busy         = busy_q;
  assign rdy_pulse    = rdy_q;
  assign req_tog      = req_q;
  assign held.swrst   = hold_q[SWRST_BIT];
  assign held.enable  = hold_q[ENABLE_BIT];

  // R2: busy is visible in the cycle following acceptance
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ready && is_ctrl) |=> busy);

  // R4: a control write seen while busy is stalled
  assert_stall_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_ctrl && busy) |-> !ready);

  // R7: other addresses never stall
  assert_no_stall_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !is_ctrl) |-> ready);

  // R3: ready flag lasts one cycle and follows a busy period
  assert_ready_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pulse |=> !rdy_pulse);
  assert_ready_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_pulse) |-> $past(busy));

  // R8: held data does not move while a transfer is in flight
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(hold_q));
endmodule

// File: rtl/regsync_core_side.sv
module regsync_core_side
  import regsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_sync,
  input  ctrl_bits_t held,
  output logic       enable,
  output logic       swrst,
  output logic       ack_tog
);
  logic enable_q, enable_d;
  logic swrst_q, swrst_d;
  logic ack_q, ack_d;
  logic apply;

  always_comb begin
    apply    = (req_sync != ack_q);
    enable_d = enable_q;
    swrst_d  = 1'b0;
    ack_d    = ack_q;
    if (apply) begin
      ack_d = req_sync;
      if (held.swrst) begin
        swrst_d  = 1'b1;
        enable_d = 1'b0;
      end else begin
        enable_d = held.enable;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      swrst_q  <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      enable_q <= enable_d;
      swrst_q  <= swrst_d;
      ack_q    <= ack_d;
    end
  end

  assign enable  = enable_q;
  assign swrst   = swrst_q;
  assign ack_tog = ack_q;

  // R6: software reset pulse clears itself and leaves enable low
  assert_swrst_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> !swrst);
  assert_swrst_clears_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |-> !enable);

  // R5: enable only changes when a request is applied
  assert_enable_only_on_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sync == ack_tog) |=> $stable(enable));
endmodule

// File: rtl/regsync_xdom.sv
module regsync_xdom
  import regsync_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int CTRL_ADDR  = 0,
  parameter int SWRST_BIT  = 0,
  parameter int ENABLE_BIT = 1,
  parameter int STAGES     = 2
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_ready,
  output logic          sync_busy,
  output logic          sync_ready_pulse,
  input  logic          core_clk,
  input  logic          core_rst_n,
  output logic          core_enable,
  output logic          core_swrst
);
  logic       bus_rst_sn, core_rst_sn;
  logic       req_tog, req_sync, ack_tog, ack_sync;
  ctrl_bits_t held;

  regsync_rst_sync #(.STAGES(STAGES)) i_bus_rst (
    .clk(bus_clk), .arst_n(bus_rst_n), .rst_n(bus_rst_sn));

  regsync_rst_sync #(.STAGES(STAGES)) i_core_rst (
    .clk(core_clk), .arst_n(core_rst_n), .rst_n(core_rst_sn));

  regsync_bus_side #(
    .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
    .SWRST_BIT(SWRST_BIT), .ENABLE_BIT(ENABLE_BIT)
  ) i_bus (
    .clk(bus_clk), .rst_n(bus_rst_sn), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .ack_sync(ack_sync), .ready(bus_ready),
    .busy(sync_busy), .rdy_pulse(sync_ready_pulse), .req_tog(req_tog),
    .held(held));

  regsync_sync_bits #(.WIDTH(1), .STAGES(STAGES)) i_req_sync (
    .clk(core_clk), .rst_n(core_rst_sn), .d(req_tog), .q(req_sync));

  regsync_core_side i_core (
    .clk(core_clk), .rst_n(core_rst_sn), .req_sync(req_sync), .held(held),
    .enable(core_enable), .swrst(core_swrst), .ack_tog(ack_tog));

  regsync_sync_bits #(.WIDTH(1), .STAGES(STAGES)) i_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_sn), .d(ack_tog), .q(ack_sync));
endmodule

// File: tb/test_regsync_xdom.sv
module test_regsync_xdom;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          bus_clk = 1'b0, core_clk = 1'b0;
  logic          bus_rst_n, core_rst_n;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ready, sync_busy, sync_ready_pulse;
  logic          core_enable, core_swrst;

  int  checks = 0, failures = 0;
  int  rdy_cnt = 0, sw_cnt = 0;
  int  exp_pulses = 0, exp_sw = 0;
  bit  exp_en = 1'b0;
  bit  prev_rdy = 1'b0, prev_sw = 1'b0;
  int  cycles = 0;

  always #5 bus_clk = ~bus_clk;
  always #7 core_clk = ~core_clk;

  regsync_xdom #(.AW(AW), .DW(DW)) i_regsync_xdom (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .sync_busy(sync_busy), .sync_ready_pulse(sync_ready_pulse),
    .core_clk(core_clk), .core_rst_n(core_rst_n),
    .core_enable(core_enable), .core_swrst(core_swrst));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit next_enable(input bit cur, input logic [DW-1:0] d);
    if (d[0]) return 1'b0;
    return d[1];
  endfunction

  // R3 pulse width and R6 pulse width monitors
  always @(negedge bus_clk) begin
    if (sync_ready_pulse) begin
      rdy_cnt++;
      chk(!prev_rdy, "R3", "ready pulse width", 2, 1);
    end
    prev_rdy = sync_ready_pulse;
  end

  always @(negedge core_clk) begin
    if (core_swrst) begin
      sw_cnt++;
      chk(!prev_sw, "R6", "swrst pulse width", 2, 1);
      chk(!core_enable, "R6", "enable during swrst", core_enable, 0);
    end
    prev_sw = core_swrst;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge bus_clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Present a write, wait out any stall, and update the model at acceptance.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int stalls);
    bit is_ctrl;
    is_ctrl = (a == '0);
    stalls = 0;
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin
      chk(sync_busy && is_ctrl, "R4", "stall without busy", sync_busy, 1);
      stalls++;
      if (stalls > 60) begin
        chk(1'b0, "R4", "stall never ends", stalls, 40);
        break;
      end
      @(negedge bus_clk); #1;
    end
    @(posedge bus_clk);
    if (is_ctrl) begin
      exp_en = next_enable(exp_en, d);
      if (d[0]) exp_sw++;
      exp_pulses++;
    end
    @(negedge bus_clk);
    bus_wr = 1'b0;
    bus_wdata = ~d;  // R8: later data must not matter
    if (is_ctrl) chk(sync_busy === 1'b1, "R2", "busy after accept", sync_busy, 1);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (sync_busy !== 1'b0 && n < 60) begin
      @(negedge bus_clk); n++;
    end
    chk(n <= 40, "R3", "completion latency", n, 40);
    @(negedge bus_clk);
    @(negedge bus_clk);
    chk(core_enable === exp_en, "R5", "core_enable", core_enable, exp_en);
    chk(rdy_cnt == exp_pulses, "R3", "ready pulse count", rdy_cnt, exp_pulses);
    chk(sw_cnt == exp_sw, "R6", "swrst pulse count", sw_cnt, exp_sw);
  endtask

  initial begin
    int st;
    int r;
    logic [DW-1:0] d;
    void'($urandom(32'h5EED_0042));
    bus_rst_n = 1'b0; core_rst_n = 1'b0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge bus_clk);
    bus_rst_n = 1'b1; core_rst_n = 1'b1;
    repeat (6) @(negedge bus_clk);

    // R1 reset state
    chk(sync_busy === 1'b0, "R1", "busy after reset", sync_busy, 0);
    chk(bus_ready === 1'b1, "R1", "ready after reset", bus_ready, 1);
    chk(core_enable === 1'b0, "R1", "enable after reset", core_enable, 0);
    chk(core_swrst === 1'b0, "R1", "swrst after reset", core_swrst, 0);
    chk(rdy_cnt == 0, "R1", "no ready pulse", rdy_cnt, 0);

    // R5 enable set, R8 data changed after accept
    do_write('0, 8'h02, st);
    chk(st == 0, "R2", "no stall when idle", st, 0);
    wait_idle();
    chk(core_enable === 1'b1, "R8", "held data applied", core_enable, 1);

    // R7 other address, idle and during a transfer
    do_write(4'h3, 8'h01, st);
    chk(sync_busy === 1'b0, "R7", "busy on other addr", sync_busy, 0);
    repeat (30) @(negedge bus_clk);
    chk(rdy_cnt == exp_pulses, "R7", "no pulse on other addr", rdy_cnt, exp_pulses);
    chk(core_enable === 1'b1, "R7", "enable untouched", core_enable, 1);
    chk(sw_cnt == exp_sw, "R7", "no swrst on other addr", sw_cnt, exp_sw);

    // R4 back-to-back control writes stall; R7 no stall while busy
    do_write('0, 8'h00, st);
    do_write(4'h5, 8'hFF, st);
    chk(st == 0, "R7", "other addr stalled while busy", st, 0);
    do_write('0, 8'h02, st);
    chk(st > 0, "R4", "second control write stalled", st, 1);
    wait_idle();

    // R6 swrst with enable bit set still clears enable
    do_write('0, 8'h03, st);
    wait_idle();
    chk(core_enable === 1'b0, "R6", "enable after swrst", core_enable, 0);

    // Random mix
    for (int i = 0; i < 200; i++) begin
      r = $urandom % 8;
      d = DW'($urandom);
      if (r < 5)       do_write('0, d, st);
      else if (r == 5) do_write(AW'(1 + ($urandom % 15)), d, st);
      else if (r == 6) wait_idle();
      else             repeat ($urandom % 5) @(negedge bus_clk);
    end
    wait_idle();
    finish_run();
  end
endmodule